// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor data path. In a single combinational pass it takes an operation code, a destination operand, a source operand (a register value or an immediate) and the current status byte. From these it produces a result byte, a write-enable for that result, and the next status byte. A status register captures the next status on every cycle in which the enable is high. The surrounding core can then return that register to `stat_in` on the following operation.

Each class of operation updates only its own set of flags. Add and subtract form half-carry, carry and overflow from bitwise carry and borrow vectors. Subtract-with-carry and compare-with-carry keep the zero flag sticky, so that a chain of byte operations reports zero only when every byte was zero. The interrupt-enable and transfer flags are never changed.

Top module: `alu8_flags`

## Requirements
- R1: Status bit order is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. The op code 0x0 adds `opa + opb`, and 0x1 adds `opa + opb + C_in`. Both set H from the carry out of bit 3, C from the carry out of bit 7, V on signed overflow, N from result bit 7, Z on a zero result, and S = N xor V.
- R2: Op codes 0x2 (subtract), 0x3 (subtract with carry), 0x4 (compare) and 0x5 (compare with carry) compute `opa - opb`, minus C_in for 0x3 and 0x5. They set H on a borrow from bit 4, C on a borrow out of bit 7, V on signed overflow, N from bit 7 and S = N xor V. For codes 0x2 and 0x4, Z is set exactly when the result is zero.
- R3: For codes 0x3 and 0x5, Z is set only when the result is zero and Z_in is 1. In every other case they clear Z.
- R4: Compare codes 0x4 and 0x5 drive `wr_en` low. Every other code from 0x0 to 0xE drives `wr_en` high.
- R5: Code 0x6 is AND, 0x7 is OR and 0x8 is XOR. Each clears V, copies result bit 7 into both N and S, sets Z on a zero result, and leaves C and H at their input values.
- R6: Code 0x9 returns the one's complement of `opa`. It updates V, N, S and Z as in R5, forces C to 1 and leaves H unchanged.
- R7: Code 0xA returns the two's complement of `opa`. C is set when the result is nonzero, V is set only for a result of 0x80, H is bit 3 of (result | opa), N is result bit 7, S = N xor V, and Z is set on a zero result.
- R8: Code 0xB exchanges the two nibbles of `opa` and returns all flags unchanged.
- R9: Codes 0xC, 0xD and 0xE shift `opa` right by one. Bit 7 of the result is `opa[7]` for 0xC, 0 for 0xD and C_in for 0xE. C is `opa[0]`, N is result bit 7, V = N xor C, S = N xor V, Z is set on a zero result, and H is unchanged.
- R10: For every op code, I and T in `stat_next` equal their values in `stat_in`.
- R11: `stat_q` is 0 after reset. It loads `stat_next` on a rising clock edge when `en` is 1, and holds its value when `en` is 0.
- R12: Op code 0xF is reserved. It returns `opa` as the result, drives `wr_en` low and leaves `stat_next` equal to `stat_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Load `stat_next` into `stat_q` |
| op | input | 4 | Operation code |
| opa | input | 8 | Destination operand |
| opb | input | 8 | Source operand or immediate |
| stat_in | input | 8 | Current status flags |
| res | output | 8 | Result byte |
| wr_en | output | 1 | Result is to be written back |
| stat_next | output | 8 | Next status flags |
| stat_q | output | 8 | Registered status flags |

## Verification
The bench builds the block with its default data width of 8. At this width the half-carry sits at bit 3 and the sign at bit 7, and every operand pair is a legal 8-bit value. Random operands and random incoming status bytes cover both carry-in values and both old Z values for the chained subtract and compare codes. Directed cases cover the 0x7F/0x80 signed boundaries, the negation of 0x00 and 0x80, and zero results that have to be reported as nonzero because the incoming Z flag was clear.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [3:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [7:0]    stat_in,
  output logic [DW-1:0] res,
  output logic          wr_en,
  output logic [7:0]    stat_next,
  output logic [7:0]    stat_q
);
  localparam int MSB = DW - 1;
  localparam int HB  = DW / 2 - 1;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  localparam logic [3:0] OP_ADD = 4'h0, OP_ADC = 4'h1, OP_SUB = 4'h2, OP_SBC = 4'h3,
                         OP_CP  = 4'h4, OP_CPC = 4'h5, OP_AND = 4'h6, OP_OR  = 4'h7,
                         OP_XOR = 4'h8, OP_COM = 4'h9, OP_NEG = 4'hA, OP_SWP = 4'hB,
                         OP_ASR = 4'hC, OP_LSR = 4'hD, OP_ROR = 4'hE;

  logic          cin;
  logic          chain;
  logic [DW-1:0] add_r, sub_r, neg_r;
  logic [DW-1:0] add_cv, add_ov, sub_bv, sub_ov;
  logic          fh, fs, fv, fn, fz, fc;

  assign cin   = stat_in[FC];
  assign chain = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);

  assign add_r = opa + opb + {{(DW-1){1'b0}}, chain & cin};
  assign sub_r = opa - opb - {{(DW-1){1'b0}}, chain & cin};
  assign neg_r = '0 - opa;

  assign add_cv = (opa & opb) | (opa & ~add_r) | (opb & ~add_r);
  assign add_ov = (opa & opb & ~add_r) | (~opa & ~opb & add_r);
  assign sub_bv = (~opa & opb) | (opb & sub_r) | (sub_r & ~opa);
  assign sub_ov = (opa & ~opb & ~sub_r) | (~opa & opb & sub_r);

  always_comb begin
    res   = opa;
    wr_en = 1'b1;
    fh = stat_in[FH];
    fs = stat_in[FS];
    fv = stat_in[FV];
    fn = stat_in[FN];
    fz = stat_in[FZ];
    fc = stat_in[FC];
    case (op)
      OP_ADD, OP_ADC: begin
        res = add_r;
        fh  = add_cv[HB];
        fc  = add_cv[MSB];
        fv  = add_ov[MSB];
        fn  = add_r[MSB];
        fz  = (add_r == '0);
        fs  = fn ^ fv;
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC: begin
        res   = sub_r;
        wr_en = (op == OP_SUB) || (op == OP_SBC);
        fh    = sub_bv[HB];
        fc    = sub_bv[MSB];
        fv    = sub_ov[MSB];
        fn    = sub_r[MSB];
        fz    = (sub_r == '0) && (!chain || stat_in[FZ]);
        fs    = fn ^ fv;
      end
      OP_AND, OP_OR, OP_XOR, OP_COM: begin
        case (op)
          OP_AND:  res = opa & opb;
          OP_OR:   res = opa | opb;
          OP_XOR:  res = opa ^ opb;
          default: res = ~opa;
        endcase
        fv = 1'b0;
        fn = res[MSB];
        fs = res[MSB];
        fz = (res == '0);
        if (op == OP_COM) fc = 1'b1;
      end
      OP_NEG: begin
        res = neg_r;
        fh  = neg_r[HB] | opa[HB];
        fc  = (neg_r != '0);
        fv  = (neg_r == {1'b1, {(DW-1){1'b0}}});
        fn  = neg_r[MSB];
        fz  = (neg_r == '0);
        fs  = fn ^ fv;
      end
      OP_SWP: res = {opa[HB:0], opa[MSB:HB+1]};
      OP_ASR, OP_LSR, OP_ROR: begin
        case (op)
          OP_ASR:  res = {opa[MSB], opa[MSB:1]};
          OP_LSR:  res = {1'b0, opa[MSB:1]};
          default: res = {cin, opa[MSB:1]};
        endcase
        fc = opa[0];
        fn = res[MSB];
        fv = fn ^ fc;
        fs = fn ^ fv;
        fz = (res == '0);
      end
      default: wr_en = 1'b0;
    endcase
  end

  assign stat_next = {stat_in[7:6], fh, fs, fv, fn, fz, fc};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  stat_q <= '0;
    else if (en) stat_q <= stat_next;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [3:0]    op,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic [7:0]    stat_in,
  input logic [DW-1:0] res,
  input logic          wr_en,
  input logic [7:0]    stat_next,
  input logic [7:0]    stat_q
);
  localparam int HB = DW / 2 - 1;

  p_arith_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op <= 4'h5) |-> (stat_next[4] == (stat_next[2] ^ stat_next[3])));

  p_sticky_z_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 4'h3 || op == 4'h5) && !stat_in[1]) |-> !stat_next[1]);

  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h4 || op == 4'h5) |-> !wr_en);

  p_com_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h9) |-> (stat_next[0] && res == ~opa));

  p_swap_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'hB) |-> (stat_next == stat_in && res == {opa[HB:0], opa[DW-1:HB+1]}));

  p_it_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_next[7:6] == stat_in[7:6]);

  p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (stat_q == $past(stat_next)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(stat_q));

  p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'hF) |-> (!wr_en && stat_next == stat_in && res == opa));
endmodule

bind alu8_flags alu8_flags_chk #(.DW(DW)) chk_i (.*);

// File: tb/alu8_flags_tb_top.sv
module alu8_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] op = 4'h0;
  logic [7:0] opa = 8'h00, opb = 8'h00, stat_in = 8'h00;
  logic [7:0] res, stat_next, stat_q;
  logic       wr_en;

  int tests = 0;
  int fails = 0;
  logic [7:0] q_model = 8'h00;

  always #5 clk = ~clk;

  alu8_flags dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opa(opa), .opb(opb),
    .stat_in(stat_in), .res(res), .wr_en(wr_en), .stat_next(stat_next), .stat_q(stat_q)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'h0, 4'h1:             return "R1";
      4'h2, 4'h4:             return "R2";
      4'h3, 4'h5:             return "R3";
      4'h6, 4'h7, 4'h8:       return "R5";
      4'h9:                   return "R6";
      4'hA:                   return "R7";
      4'hB:                   return "R8";
      4'hC, 4'hD, 4'hE:       return "R9";
      default:                return "R12";
    endcase
  endfunction

  // returns {wr, result, status}
  function automatic logic [16:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] s);
    logic [7:0] r;
    logic w, c, z, n, v, sg, h;
    int ci, full;
    c = s[0]; z = s[1]; n = s[2]; v = s[3]; sg = s[4]; h = s[5];
    w = 1'b1; r = a;
    ci = ((o == 4'h1) || (o == 4'h3) || (o == 4'h5)) ? int'(s[0]) : 0;
    if (o <= 4'h1) begin
      full = int'(a) + int'(b) + ci;
      r = full[7:0];
      c = full > 255;
      h = (int'(a & 8'h0F) + int'(b & 8'h0F) + ci) > 15;
      v = (a[7] == b[7]) && (r[7] != a[7]);
      n = r[7]; z = (r == 0); sg = n ^ v;
    end else if (o <= 4'h5) begin
      full = int'(a) - int'(b) - ci;
      r = full[7:0];
      c = int'(a) < int'(b) + ci;
      h = int'(a & 8'h0F) < int'(b & 8'h0F) + ci;
      v = (a[7] != b[7]) && (r[7] != a[7]);
      n = r[7]; sg = n ^ v;
      z = (r == 0) && ((o == 4'h2 || o == 4'h4) || s[1]);
      w = (o == 4'h2) || (o == 4'h3);
    end else if (o <= 4'h9) begin
      r = (o == 4'h6) ? (a & b) : (o == 4'h7) ? (a | b) : (o == 4'h8) ? (a ^ b) : (8'hFF - a);
      v = 0; n = r[7]; sg = r[7]; z = (r == 0);
      if (o == 4'h9) c = 1;
    end else if (o == 4'hA) begin
      full = 256 - int'(a);
      r = full[7:0];
      c = (r != 0); v = (r == 8'h80); h = r[3] | a[3];
      n = r[7]; sg = n ^ v; z = (r == 0);
    end else if (o == 4'hB) begin
      r = {a[3:0], a[7:4]};
    end else if (o <= 4'hE) begin
      r = a >> 1;
      if (o == 4'hC) r[7] = a[7];
      if (o == 4'hE) r[7] = s[0];
      c = a[0]; n = r[7]; v = n ^ c; sg = n ^ v; z = (r == 0);
    end else begin
      w = 1'b0;
    end
    return {w, r, s[7:6], h, sg, v, n, z, c};
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] s, input logic e);
    logic [16:0] ex;
    @(negedge clk);
    op = o; opa = a; opb = b; stat_in = s; en = e;
    #1;
    ex = model(o, a, b, s);
    check(req_of(o), "result", res, ex[15:8]);
    check((o == 4'h4 || o == 4'h5 || o == 4'hF) ? "R4" : "R4", "wr_en", {7'd0, wr_en}, {7'd0, ex[16]});
    check(req_of(o), "status", stat_next, ex[7:0]);
    check("R10", "I/T", {6'd0, stat_next[7:6]}, {6'd0, s[7:6]});
    if (e) q_model = ex[7:0];
    @(posedge clk); #1;
    check("R11", "stat_q", stat_q, q_model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    #1 check("R11", "reset stat_q", stat_q, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    step(4'h0, 8'h7F, 8'h01, 8'h00, 1);  // R1 V,H,N
    step(4'h0, 8'hFF, 8'h01, 8'h00, 1);  // R1 C,Z,H
    step(4'h1, 8'h0F, 8'h00, 8'h01, 1);  // R1 carry-in
    step(4'h2, 8'h80, 8'h01, 8'h00, 1);  // R2 overflow
    step(4'h4, 8'h10, 8'h10, 8'h00, 1);  // R2 zero compare
    step(4'h3, 8'h05, 8'h04, 8'h03, 1);  // R3 zero, Z_in set
    step(4'h3, 8'h05, 8'h04, 8'h01, 1);  // R3 zero, Z_in clear
    step(4'h5, 8'h00, 8'h00, 8'h00, 1);  // R3 compare zero, Z_in clear
    step(4'h5, 8'h00, 8'h00, 8'h02, 1);  // R3 compare zero, Z_in set
    step(4'h9, 8'h00, 8'h00, 8'h20, 1);  // R6
    step(4'hA, 8'h80, 8'h00, 8'h00, 1);  // R7 0x80
    step(4'hA, 8'h00, 8'h00, 8'h3F, 1);  // R7 zero
    step(4'hA, 8'h01, 8'h00, 8'h00, 1);  // R7
    step(4'hB, 8'hA5, 8'h00, 8'hFF, 1);  // R8
    step(4'hC, 8'h81, 8'h00, 8'h00, 1);  // R9 asr
    step(4'hD, 8'h01, 8'h00, 8'h00, 1);  // R9 lsr to zero
    step(4'hE, 8'h02, 8'h00, 8'h01, 1);  // R9 ror with C
    step(4'hF, 8'h3C, 8'hC3, 8'h5A, 1);  // R12
    step(4'h6, 8'hF0, 8'h0F, 8'hE1, 0);  // R5, R11 hold
    step(4'h7, 8'h80, 8'h00, 8'h21, 1);  // R5
    step(4'h8, 8'hAA, 8'hAA, 8'hC0, 1);  // R5, R10

    for (int i = 0; i < 3000; i++)
      step(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule